// File: doc/BRIEF.md
# Interrupt Request Latch and Arbiter

This block watches the two interrupt request lines of a processor core and, whenever the fetch unit reaches an instruction boundary, decides what the next sequence is. The choices are an ordinary opcode fetch, a non-maskable service, or a maskable service in one of three modes. The non-maskable line is edge-triggered and stays pending until it is serviced. The maskable line is a plain level, re-sampled on every tick.

The fetch unit raises `fetch_req` for one cycle at each boundary, together with its current halt state and program counter. One cycle later the block answers. `seq_valid` is high for that one cycle and `seq_sel` carries the chosen sequence. When an accepted interrupt ends a halt, `halt_clr` is raised and `pc_out` points one past the halt opcode. Otherwise `pc_out` echoes the counter that was presented. The bus cycles of the acknowledge and the stack pushes belong to other blocks.

The block contains two small state machines:
- **Grant machine.** Its states are `ARB_IDLE` and `ARB_GRANT`. `ARB_IDLE -> ARB_GRANT` is taken on a boundary request. `ARB_GRANT -> ARB_GRANT` is taken on a back-to-back request. `ARB_GRANT -> ARB_IDLE` is taken otherwise.
- **Edge latch for the non-maskable line.** Its states are `NL_CLEAR` and `NL_PENDING`. `NL_CLEAR -> NL_PENDING` is taken on a detected rising edge. `NL_PENDING -> NL_CLEAR` is taken when the pending request is taken at a boundary and no new edge arrives in the same cycle.

Top module: `irq_arbiter`

## Requirements
- R1: While reset is asserted, `seq_valid`, `seq_sel`, `halt_clr` and `pc_out` are all zero.
- R2: `seq_valid` is high in exactly the cycle after each cycle with `fetch_req` high and low otherwise; `seq_sel` and `halt_clr` are zero whenever `seq_valid` is low.
- R3: A low-to-high change of `nmi_pin` between two consecutive clock samples makes a non-maskable request pending; keeping the pin high produces no further request, so it is serviced exactly once.
- R4: At a boundary with a non-maskable request pending, `seq_sel` is 1 (non-maskable service) whatever `int_pin`, `iff1` and `im_mode` are.
- R5: The maskable request is the level of `int_pin` sampled at the clock edge before the boundary; a pulse that has fallen by then is not serviced and leaves no trace.
- R6: With `iff1` low, a maskable request is ignored and the boundary gives `seq_sel` 0 (normal fetch).
- R7: An accepted maskable request selects by `im_mode`: 0 gives `seq_sel` 2, 1 gives 3, 2 gives 4, and 3 gives 3.
- R8: When the selection is nonzero and `halt_in` is high at the boundary, `halt_clr` is 1 and `pc_out` is `pc_in + 1` modulo 2^PC_W; otherwise `halt_clr` is 0 and `pc_out` equals `pc_in` of the boundary cycle.
- R9: Servicing a non-maskable request clears it, but a rising edge of `nmi_pin` in the same cycle as that boundary leaves a new request pending.
- R10: With nothing pending, a boundary gives `seq_sel` 0 (normal fetch) and `halt_clr` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_pin | input | 1 | Non-maskable request line, edge-triggered |
| int_pin | input | 1 | Maskable request line, level |
| iff1 | input | 1 | Maskable interrupt enable flag |
| im_mode | input | 2 | Maskable interrupt mode, 0 to 3 |
| fetch_req | input | 1 | Instruction boundary strobe from the fetch unit |
| halt_in | input | 1 | Core is currently halted |
| pc_in | input | PC_W | Program counter at the boundary |
| seq_valid | output | 1 | Decision valid, one cycle after `fetch_req` |
| seq_sel | output | 3 | 0 fetch, 1 non-maskable, 2/3/4 maskable mode 0/1/2 |
| halt_clr | output | 1 | Leave the halt state |
| pc_out | output | PC_W | Program counter for the chosen sequence |

## Verification
Several properties are checked on every cycle:
- the one-cycle timing of `seq_valid`;
- zero selections outside a grant;
- the non-maskable priority whenever a request is pending;
- the suppression of maskable requests with `iff1` low;
- the program counter echo or bump against the sampled `pc_in`;
- the fact that a pending request only appears after a pin rise.

Other behaviours need the bench's scenarios, which compare against a cycle model:
- that a pin held high is serviced only once;
- that a short maskable pulse is forgotten;
- that a new edge survives the clearing grant;
- the wrap of the counter at all ones.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    typedef enum logic [2:0] {
        SEL_FETCH = 3'd0,
        SEL_NMI   = 3'd1,
        SEL_IM0   = 3'd2,
        SEL_IM1   = 3'd3,
        SEL_IM2   = 3'd4
    } seq_sel_e;

    typedef enum logic {
        ARB_IDLE  = 1'b0,
        ARB_GRANT = 1'b1
    } arb_state_e;

    typedef enum logic {
        NL_CLEAR   = 1'b0,
        NL_PENDING = 1'b1
    } nmi_state_e;

endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch
    import irq_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_pin,
    input  logic take,
    output logic pending
);

    nmi_state_e state_q, state_d;
    logic       pin_q;
    logic       rise;

    assign rise = nmi_pin & ~pin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= NL_CLEAR;
            pin_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pin_q   <= nmi_pin;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NL_CLEAR:   if (rise) state_d = NL_PENDING;
            NL_PENDING: if (take && !rise) state_d = NL_CLEAR;
            default:    state_d = NL_CLEAR;
        endcase
    end

    assign pending = (state_q == NL_PENDING);

endmodule

// File: rtl/irq_level_sample.sv
module irq_level_sample (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic level_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_in;
    end

endmodule

// File: rtl/irq_select.sv
module irq_select
    import irq_arb_pkg::*;
(
    input  logic       nmi_pend,
    input  logic       int_lvl,
    input  logic       iff1,
    input  logic [1:0] im_mode,
    output seq_sel_e   sel,
    output logic       accept
);

    seq_sel_e mode_sel;

    always_comb begin
        unique case (im_mode)
            2'd0:    mode_sel = SEL_IM0;
            2'd2:    mode_sel = SEL_IM2;
            default: mode_sel = SEL_IM1;
        endcase
    end

    always_comb begin
        if (nmi_pend)            sel = SEL_NMI;
        else if (int_lvl && iff1) sel = mode_sel;
        else                     sel = SEL_FETCH;
    end

    assign accept = (sel != SEL_FETCH);

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            nmi_pin,
    input  logic            int_pin,
    input  logic            iff1,
    input  logic [1:0]      im_mode,
    input  logic            fetch_req,
    input  logic            halt_in,
    input  logic [PC_W-1:0] pc_in,
    output logic            seq_valid,
    output logic [2:0]      seq_sel,
    output logic            halt_clr,
    output logic [PC_W-1:0] pc_out
);

    localparam logic [PC_W-1:0] PC_STEP = PC_W'(1);

    arb_state_e     state_q, state_d;
    logic           nmi_pend;
    logic           int_lvl;
    logic           accept;
    logic           take_nmi;
    seq_sel_e       sel;
    seq_sel_e       sel_q;
    logic           halt_clr_q;
    logic [PC_W-1:0] pc_q;

    assign take_nmi = fetch_req & nmi_pend;

    irq_nmi_latch u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .nmi_pin (nmi_pin),
        .take    (take_nmi),
        .pending (nmi_pend)
    );

    irq_level_sample u_int (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (int_pin),
        .level_q  (int_lvl)
    );

    irq_select u_sel (
        .nmi_pend (nmi_pend),
        .int_lvl  (int_lvl),
        .iff1     (iff1),
        .im_mode  (im_mode),
        .sel      (sel),
        .accept   (accept)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE:  state_d = fetch_req ? ARB_GRANT : ARB_IDLE;
            ARB_GRANT: state_d = fetch_req ? ARB_GRANT : ARB_IDLE;
            default:   state_d = ARB_IDLE;
        endcase
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q      <= SEL_FETCH;
            halt_clr_q <= 1'b0;
            pc_q       <= '0;
        end else if (fetch_req) begin
            sel_q      <= sel;
            halt_clr_q <= accept & halt_in;
            pc_q       <= (accept && halt_in) ? pc_in + PC_STEP : pc_in;
        end else begin
            sel_q      <= SEL_FETCH;
            halt_clr_q <= 1'b0;
        end
    end

    assign seq_valid = (state_q == ARB_GRANT);
    assign seq_sel   = sel_q;
    assign halt_clr  = halt_clr_q;
    assign pc_out    = pc_q;

endmodule

// File: rtl/irq_arbiter_checker.sv
module irq_arbiter_checker #(
    parameter int PC_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            nmi_pin,
    input logic            iff1,
    input logic            fetch_req,
    input logic            halt_in,
    input logic [PC_W-1:0] pc_in,
    input logic            nmi_pend,
    input logic            seq_valid,
    input logic [2:0]      seq_sel,
    input logic            halt_clr,
    input logic [PC_W-1:0] pc_out
);

    a_r2_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |=> seq_valid);
    a_r2_no_valid_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_req |=> !seq_valid);
    a_r2_quiet_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_valid |-> (seq_sel == 3'd0 && !halt_clr));
    a_r4_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && nmi_pend) |=> (seq_sel == 3'd1));
    a_r6_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !nmi_pend && !iff1) |=> (seq_sel == 3'd0));
    a_r3_pend_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_pend) |-> $past(nmi_pin));
    a_r8_halt_bump: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && halt_in) |=> (halt_clr == (seq_sel != 3'd0)));
    a_r8_pc_bump: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && halt_in && !iff1 && !nmi_pend) |=> (pc_out == $past(pc_in)));
    a_r8_pc_nmi: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && nmi_pend && halt_in) |=> (pc_out == $past(pc_in) + PC_W'(1)));
    a_r7_sel_range: assert property (@(posedge clk) disable iff (!rst_n)
        seq_valid |-> (seq_sel <= 3'd4));

endmodule

bind irq_arbiter irq_arbiter_checker #(.PC_W(PC_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .nmi_pin   (nmi_pin),
    .iff1      (iff1),
    .fetch_req (fetch_req),
    .halt_in   (halt_in),
    .pc_in     (pc_in),
    .nmi_pend  (nmi_pend),
    .seq_valid (seq_valid),
    .seq_sel   (seq_sel),
    .halt_clr  (halt_clr),
    .pc_out    (pc_out)
);

// File: tb/irq_arbiter_tb_top.sv
`timescale 1ns/1ps
module irq_arbiter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_pin = 1'b0, int_pin = 1'b0, iff1 = 1'b0;
    logic [1:0]  im_mode = 2'd0;
    logic        fetch_req = 1'b0, halt_in = 1'b0;
    logic [15:0] pc_in = 16'd0;
    logic        seq_valid, halt_clr;
    logic [2:0]  seq_sel;
    logic [15:0] pc_out;

    int checks = 0;
    int errors = 0;
    int nmi_seen = 0;
    int int_seen = 0;
    string cur_tag = "R10";

    always #5 clk = ~clk;

    irq_arbiter #(.PC_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .int_pin(int_pin),
        .iff1(iff1), .im_mode(im_mode), .fetch_req(fetch_req), .halt_in(halt_in),
        .pc_in(pc_in), .seq_valid(seq_valid), .seq_sel(seq_sel),
        .halt_clr(halt_clr), .pc_out(pc_out)
    );

    // behavioural reference
    logic        m_prev, m_pend, m_int;
    logic        e_valid, e_halt;
    logic [2:0]  e_sel;
    logic [15:0] e_pc;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_prev = 0; m_pend = 0; m_int = 0;
            e_valid = 0; e_sel = 0; e_halt = 0; e_pc = 0;
        end else begin
            logic took;
            took = 0;
            e_valid = fetch_req;
            if (fetch_req) begin
                if (m_pend) begin e_sel = 1; took = 1; end
                else if (m_int && iff1)
                    e_sel = (im_mode == 2'd0) ? 3'd2 : (im_mode == 2'd2) ? 3'd4 : 3'd3;
                else e_sel = 0;
                e_halt = (e_sel != 0) && halt_in;
                e_pc = e_halt ? pc_in + 16'd1 : pc_in;
            end else begin
                e_sel = 0; e_halt = 0;
            end
            m_pend = (took ? 1'b0 : m_pend) | (nmi_pin & ~m_prev);
            m_prev = nmi_pin;
            m_int = int_pin;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            check(seq_valid == e_valid, "R2", seq_valid, e_valid, "seq_valid");
            check(seq_sel == e_sel, cur_tag, seq_sel, e_sel, "seq_sel");
            check(halt_clr == e_halt, "R8", halt_clr, e_halt, "halt_clr");
            check(pc_out == e_pc, "R8", pc_out, e_pc, "pc_out");
            if (seq_valid && seq_sel == 3'd1) nmi_seen++;
            if (seq_valid && seq_sel >= 3'd2) int_seen++;
        end
    end

    task automatic drive(input logic n, input logic i, input logic ie, input logic [1:0] im,
                         input logic f, input logic h, input logic [15:0] pc);
        nmi_pin = n; int_pin = i; iff1 = ie; im_mode = im;
        fetch_req = f; halt_in = h; pc_in = pc;
        @(negedge clk);
    endtask

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog R2 actual=running expected=done");
        report();
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(seq_valid == 0 && seq_sel == 0 && halt_clr == 0 && pc_out == 0, "R1",
              {seq_valid, seq_sel, halt_clr}, 0, "reset outputs");
        rst_n = 1'b1;

        // R10 nothing pending
        cur_tag = "R10";
        drive(0, 0, 1, 1, 1, 0, 16'h1000);
        drive(0, 0, 1, 1, 1, 1, 16'h1001);
        drive(0, 0, 1, 1, 0, 0, 16'h1002);

        // R3 pulse then boundary; held level serviced once
        cur_tag = "R3";
        drive(1, 0, 0, 0, 0, 0, 16'h2000);
        drive(0, 0, 0, 0, 0, 0, 16'h2000);
        drive(0, 0, 0, 0, 1, 0, 16'h2000);
        drive(0, 0, 0, 0, 0, 0, 16'h2000);
        base = nmi_seen;
        for (int k = 0; k < 30; k++) drive(1, 0, 1, 1, (k % 3) == 2, 0, 16'h2100 + 16'(k));
        drive(1, 0, 1, 1, 0, 0, 16'h2200);
        check(nmi_seen - base == 1, "R3", nmi_seen - base, 1, "services for held pin");
        drive(0, 0, 1, 1, 0, 0, 16'h2200);

        // R6 masked level never serviced
        cur_tag = "R6";
        base = int_seen;
        for (int k = 0; k < 20; k++) drive(0, 1, 0, 2, k[0], 0, 16'h3000 + 16'(k));
        drive(0, 0, 0, 2, 0, 0, 16'h3000);
        check(int_seen - base == 0, "R6", int_seen - base, 0, "masked services");

        // R7 each mode
        cur_tag = "R7";
        for (int m = 0; m < 4; m++) begin
            drive(0, 1, 1, 2'(m), 0, 0, 16'h4000);
            drive(0, 1, 1, 2'(m), 1, 0, 16'h4000 + 16'(m));
            drive(0, 0, 1, 2'(m), 0, 0, 16'h4000);
            check(int_seen > 0, "R7", int_seen, 1, "mode service seen");
        end

        // R4 both pending, enable off
        cur_tag = "R4";
        drive(1, 1, 0, 2, 0, 0, 16'h5000);
        drive(0, 1, 0, 2, 1, 0, 16'h5001);
        drive(0, 1, 1, 2, 0, 0, 16'h5002);
        drive(1, 1, 1, 0, 0, 0, 16'h5003);
        drive(0, 1, 1, 0, 1, 0, 16'h5004);
        drive(0, 0, 1, 0, 0, 0, 16'h5005);

        // R5 short maskable pulse forgotten
        cur_tag = "R5";
        base = int_seen;
        drive(0, 1, 1, 1, 0, 0, 16'h6000);
        drive(0, 0, 1, 1, 0, 0, 16'h6000);
        drive(0, 0, 1, 1, 1, 0, 16'h6001);
        drive(0, 0, 1, 1, 0, 0, 16'h6002);
        check(int_seen - base == 0, "R5", int_seen - base, 0, "pulse services");

        // R8 halt exit with wrap, and halted without interrupt
        cur_tag = "R8";
        drive(0, 1, 1, 1, 0, 1, 16'hFFFF);
        drive(0, 1, 1, 1, 1, 1, 16'hFFFF);
        drive(0, 1, 1, 1, 0, 1, 16'hFFFF);
        check(pc_out == 16'h0000, "R8", pc_out, 0, "wrapped pc");
        drive(0, 0, 0, 1, 1, 1, 16'h7000);
        drive(0, 0, 0, 1, 0, 1, 16'h7000);
        drive(1, 0, 0, 1, 0, 1, 16'h7100);
        drive(0, 0, 0, 1, 1, 1, 16'h7100);
        drive(0, 0, 0, 1, 0, 0, 16'h7100);
        check(pc_out == 16'h7101, "R8", pc_out, 16'h7101, "nmi halt bump");

        // R9 new edge in the clearing cycle survives
        cur_tag = "R9";
        base = nmi_seen;
        drive(1, 0, 0, 0, 0, 0, 16'h8000);
        drive(0, 0, 0, 0, 0, 0, 16'h8000);
        drive(1, 0, 0, 0, 1, 0, 16'h8001);
        drive(1, 0, 0, 0, 0, 0, 16'h8002);
        drive(1, 0, 0, 0, 1, 0, 16'h8003);
        drive(1, 0, 0, 0, 1, 0, 16'h8004);
        drive(0, 0, 0, 0, 0, 0, 16'h8005);
        check(nmi_seen - base == 2, "R9", nmi_seen - base, 2, "services around clearing");

        // R2 back-to-back boundaries
        cur_tag = "R2";
        drive(0, 0, 0, 0, 1, 0, 16'h9000);
        drive(0, 0, 0, 0, 1, 0, 16'h9001);
        drive(0, 0, 0, 0, 1, 0, 16'h9002);
        drive(0, 0, 0, 0, 0, 0, 16'h9003);
        drive(0, 0, 0, 0, 0, 0, 16'h9003);
        check(seq_valid == 0, "R2", seq_valid, 0, "idle after burst");

        report();
    end

endmodule